// File: doc/BRIEF.md
# Triple Programmable Interval Timer

This block is a bus-attached peripheral with three 16-bit down-counters. A byte-wide register port carries the control words, a status byte and the counter preload and readback bytes. Each counter counts enable pulses. It can use the shared internal tick or its own alternate source, and for timer 2 that alternate source is the expiry pulse of timer 3. Using timer 3 in this way stretches the period of timer 2. When a counter expires it reloads from its latch, sets its flag and toggles its output state. The status byte gathers the three flags and a composite flag, and the composite flag also drives the interrupt pin.

All logic runs in one synchronous clock domain. Counting happens only on cycles where the selected enable pulse is high. Each counter is controlled by a two-state machine: `CNT_HOLD` loads the latch every cycle, and `CNT_RUN` counts. Both states take the transition to `CNT_HOLD` when the chip-hold bit is set and the transition to `CNT_RUN` when it is clear. A second two-state machine per timer handles flag clearing. It moves from `CLR_IDLE` to `CLR_ARMED` on a status read while the flag is set. It moves from `CLR_ARMED` back to `CLR_IDLE` on a read of that timer's counter, and that read clears the flag.

Top module: `tri_interval_timer`

## Requirements
- R1: Register access uses odd offsets only. Offset 0x1 writes control word 1 when bit 0 of control word 2 is 1, and writes control word 3 when that bit is 0; reads of 0x1 return 0. Offset 0x3 writes control word 2 and reads the status byte. Timers 1, 2 and 3 take their high/low byte pairs at 0x5/0x7, 0x9/0xB and 0xD/0xF.
- R2: After reset, control word 1 is 0x01 (chip hold), control words 2 and 3 are 0x00, every latch and counter is 0xFFFF, and status, outputs and the interrupt are all 0.
- R3: While bit 0 of control word 1 is 1, every counter equals its latch and no timer expires.
- R4: A high-byte write goes to one shared holding byte. The following low-byte write moves both bytes into that timer's latch. If bit 4 of that timer's control word is 0, the counter is also reloaded. If bit 4 is 1, the counter keeps its value.
- R5: A high-byte read returns the live high byte and captures the live low byte. The next low-byte read returns that captured byte, even if the counter has changed since.
- R6: In 16-bit mode (control bit 2 = 0), a latch value N ≥ 1 gives one expiry every N enable pulses: a value of 2500 gives 2500 pulses and 5000 gives 5000. A value of 0 behaves as 1.
- R7: In dual 8-bit mode (control bit 2 = 1), with low latch byte L and high latch byte H, the low byte counts periods of L pulses (0 behaves as 1). The high byte counts H+1 such periods, so one expiry comes every L·(H+1) pulses.
- R8: Control bit 1 = 1 selects the internal tick. Bit 1 = 0 selects the alternate source: the external tick pin for timers 1 and 3, and the expiry pulse of timer 3 for timer 2.
- R9: Each expiry sets that timer's flag. Status bits 0, 1 and 2 carry the flags of timers 1, 2 and 3.
- R10: Status bit 7 and the interrupt output are 1 exactly when some flag is set and bit 6 of that timer's control word is 1.
- R11: A flag clears only when the status byte is read while the flag is set and a later read hits that timer's counter bytes. A counter read with no such status read leaves the flag set.
- R12: Each timer's output state toggles on every expiry. Its pin shows that state when control bit 7 is 1 and is held at 0 when bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read cycle |
| tick_int | input | 1 | Internal count-enable pulse |
| ext_tick1 | input | 1 | Alternate count enable for timer 1 |
| ext_tick3 | input | 1 | Alternate count enable for timer 3 |
| tmr_out | output | 3 | Timer output pins, bit 0 = timer 1 |
| irq | output | 1 | Composite interrupt request |

## Verification
The assertions check the following on every cycle:
- no expiry while the chip hold is set;
- each expiry leaves its flag set and flips its output state;
- a reload takes the new latch value;
- a flag only ever falls after a counter read;
- the interrupt never rises without a flag;
- a write to offset 0x1 while control word 3 is selected leaves control word 1 untouched.

Only the bench's scenarios can show the following:
- the exact periods in 16-bit, dual 8-bit and cascaded use;
- the byte pairing of reads and writes;
- the no-reload latch update;
- the order-dependent flag-clear sequence.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int NTMR   = 3;
    localparam int ADDR_W = 4;

    localparam int CB_OE      = 7;
    localparam int CB_IE      = 6;
    localparam int CB_NORLD   = 4;
    localparam int CB_M8      = 2;
    localparam int CB_INTCLK  = 1;
    localparam int CB_CHIPRST = 0;
    localparam int CB_SEL     = 0;

    typedef enum logic [0:0] {CNT_HOLD, CNT_RUN}   cnt_state_e;
    typedef enum logic [0:0] {CLR_IDLE, CLR_ARMED} clr_state_e;
endpackage

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int HALF_W = pit_pkg::BYTE_W,
    localparam int CW = 2 * HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          mode8,
    input  logic          tick,
    input  logic [CW-1:0] latch,
    input  logic          load,
    input  logic          sr_rd,
    input  logic          cnt_rd,
    input  logic          out_en,
    output logic [CW-1:0] count,
    output logic          flag,
    output logic          out_pin,
    output logic          expire
);
    cnt_state_e state_q, state_d;
    clr_state_e clr_q, clr_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          exp_now;
    logic          flag_q, flag_d;
    logic          tgl_q;
    logic          exp_q;
    logic [HALF_W-1:0] lo_q, hi_q;

    assign lo_q = cnt_q[HALF_W-1:0];
    assign hi_q = cnt_q[CW-1:HALF_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HOLD;
            clr_q   <= CLR_IDLE;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HOLD: if (!hold) state_d = CNT_RUN;
            CNT_RUN:  if (hold)  state_d = CNT_HOLD;
            default:  state_d = CNT_HOLD;
        endcase
        clr_d = clr_q;
        unique case (clr_q)
            CLR_IDLE:  if (sr_rd && flag_q) clr_d = CLR_ARMED;
            CLR_ARMED: if (cnt_rd)          clr_d = CLR_IDLE;
            default:   clr_d = CLR_IDLE;
        endcase
    end

    // counting datapath
    always_comb begin
        cnt_d   = cnt_q;
        exp_now = 1'b0;
        unique case (state_q)
            CNT_HOLD: cnt_d = latch;
            CNT_RUN: begin
                if (hold || load) begin
                    cnt_d = latch;
                end else if (tick) begin
                    if (!mode8) begin
                        if (cnt_q <= CW'(1)) begin
                            cnt_d   = latch;
                            exp_now = 1'b1;
                        end else begin
                            cnt_d = cnt_q - CW'(1);
                        end
                    end else begin
                        if (lo_q <= HALF_W'(1)) begin
                            cnt_d[HALF_W-1:0] = latch[HALF_W-1:0];
                            if (hi_q == '0) begin
                                cnt_d[CW-1:HALF_W] = latch[CW-1:HALF_W];
                                exp_now = 1'b1;
                            end else begin
                                cnt_d[CW-1:HALF_W] = hi_q - HALF_W'(1);
                            end
                        end else begin
                            cnt_d[HALF_W-1:0] = lo_q - HALF_W'(1);
                        end
                    end
                end
            end
            default: cnt_d = latch;
        endcase
        flag_d = flag_q;
        if (exp_now)
            flag_d = 1'b1;
        else if (clr_q == CLR_ARMED && cnt_rd)
            flag_d = 1'b0;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            flag_q <= 1'b0;
            tgl_q  <= 1'b0;
            exp_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            tgl_q  <= tgl_q ^ exp_now;
            exp_q  <= exp_now;
        end
    end

    assign count   = cnt_q;
    assign flag    = flag_q;
    assign expire  = exp_q;
    assign out_pin = tgl_q & out_en;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) hold |=> !expire); // R3
    AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n) expire |-> flag); // R9
    AST_OUT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) expire |-> (tgl_q != $past(tgl_q))); // R12
    AST_LOAD_TAKES_LATCH: assert property (@(posedge clk) disable iff (!rst_n) load |=> (count == $past(latch))); // R4
    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag) |-> $past(cnt_rd)); // R11
endmodule

// File: rtl/pit_regfile.sv
module pit_regfile
    import pit_pkg::*;
#(
    parameter int BW = pit_pkg::BYTE_W,
    parameter int NT = pit_pkg::NTMR,
    parameter int AW = pit_pkg::ADDR_W,
    localparam int CW = 2 * BW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [BW-1:0]         bus_wdata,
    output logic [BW-1:0]         bus_rdata,
    input  logic [NT-1:0][CW-1:0] cnt_val,
    input  logic [NT-1:0]         flags,
    output logic [NT-1:0][BW-1:0] ctl,
    output logic [NT-1:0][CW-1:0] latch,
    output logic [NT-1:0]         load,
    output logic                  sr_rd,
    output logic [NT-1:0]         cnt_rd,
    output logic                  irq
);
    logic wr_en, rd_en, odd;
    logic is_ctl13, is_ctl2, is_cnt, is_msb, is_lsb;
    logic [NT-1:0] hit;
    logic [NT-1:0] ie_vec;
    logic [BW-1:0] wr_hold_q, rd_hold_q;
    logic [BW-1:0] status;
    logic          composite;

    assign wr_en    = bus_sel & bus_wr;
    assign rd_en    = bus_sel & ~bus_wr;
    assign odd      = bus_addr[0];
    assign is_ctl13 = odd && (bus_addr[AW-1:1] == '0);
    assign is_ctl2  = odd && (bus_addr[AW-1:1] == (AW-1)'(1));
    assign is_cnt   = odd && (bus_addr[AW-1:2] != '0);
    assign is_msb   = is_cnt && !bus_addr[1];
    assign is_lsb   = is_cnt && bus_addr[1];

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            hit[t]    = is_cnt && (bus_addr[AW-1:2] == (AW-2)'(t + 1));
            ie_vec[t] = ctl[t][CB_IE];
            cnt_rd[t] = rd_en && hit[t];
        end
    end

    assign composite = |(flags & ie_vec);
    assign irq       = composite;
    assign sr_rd     = rd_en && is_ctl2;

    always_comb begin
        status          = '0;
        status[NT-1:0]  = flags;
        status[BW-1]    = composite;
    end

    always_comb begin
        bus_rdata = '0;
        if (is_ctl2) bus_rdata = status;
        for (int t = 0; t < NT; t++) begin
            if (hit[t] && is_msb) bus_rdata = cnt_val[t][CW-1:BW];
        end
        if (is_lsb) bus_rdata = rd_hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl                <= '0;
            ctl[0][CB_CHIPRST] <= 1'b1;
            latch              <= '1;
            load               <= '0;
            wr_hold_q          <= '0;
            rd_hold_q          <= '0;
        end else begin
            load <= '0;
            if (wr_en) begin
                if (is_ctl13) begin
                    if (ctl[1][CB_SEL]) ctl[0] <= bus_wdata;
                    else                ctl[NT-1] <= bus_wdata;
                end
                if (is_ctl2) ctl[1] <= bus_wdata;
                if (is_msb)  wr_hold_q <= bus_wdata;
                for (int t = 0; t < NT; t++) begin
                    if (is_lsb && hit[t]) begin
                        latch[t] <= {wr_hold_q, bus_wdata};
                        load[t]  <= !ctl[t][CB_NORLD];
                    end
                end
            end
            if (rd_en) begin
                for (int t = 0; t < NT; t++) begin
                    if (is_msb && hit[t]) rd_hold_q <= cnt_val[t][BW-1:0];
                end
            end
        end
    end

    AST_CTL_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && is_ctl13 && !ctl[1][CB_SEL]) |=> $stable(ctl[0])); // R1
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (flags != '0)); // R10
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import pit_pkg::*;
#(
    parameter int BW = pit_pkg::BYTE_W,
    parameter int AW = pit_pkg::ADDR_W,
    localparam int NT = pit_pkg::NTMR,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          tick_int,
    input  logic          ext_tick1,
    input  logic          ext_tick3,
    output logic [NT-1:0] tmr_out,
    output logic          irq
);
    logic [NT-1:0][CW-1:0] cnt_val;
    logic [NT-1:0][BW-1:0] ctl;
    logic [NT-1:0][CW-1:0] latch;
    logic [NT-1:0]         load, cnt_rd, flags, expire, alt_src, tick_sel;
    logic                  sr_rd;
    logic                  chip_hold;

    assign chip_hold = ctl[0][CB_CHIPRST];

    pit_regfile #(.BW(BW), .NT(NT), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .flags     (flags),
        .ctl       (ctl),
        .latch     (latch),
        .load      (load),
        .sr_rd     (sr_rd),
        .cnt_rd    (cnt_rd),
        .irq       (irq)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        if (g == 1) begin : g_cascade
            assign alt_src[g] = expire[NT-1];
        end else if (g == 0) begin : g_ext_first
            assign alt_src[g] = ext_tick1;
        end else begin : g_ext_last
            assign alt_src[g] = ext_tick3;
        end
        assign tick_sel[g] = ctl[g][CB_INTCLK] ? tick_int : alt_src[g];

        pit_counter #(.HALF_W(BW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (chip_hold),
            .mode8   (ctl[g][CB_M8]),
            .tick    (tick_sel[g]),
            .latch   (latch[g]),
            .load    (load[g]),
            .sr_rd   (sr_rd),
            .cnt_rd  (cnt_rd[g]),
            .out_en  (ctl[g][CB_OE]),
            .count   (cnt_val[g]),
            .flag    (flags[g]),
            .out_pin (tmr_out[g]),
            .expire  (expire[g])
        );
    end
endmodule

// File: tb/tri_interval_timer_tb_top.sv
`timescale 1ns/1ps
module tri_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_int = 1'b0;
    logic       ext_tick1 = 1'b0;
    logic       ext_tick3 = 1'b0;
    logic [2:0] tmr_out;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int tick_k = 1;
    int tick_c = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tri_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_int(tick_int), .ext_tick1(ext_tick1), .ext_tick3(ext_tick3),
        .tmr_out(tmr_out), .irq(irq)
    );

    // internal tick: one pulse every tick_k cycles
    always @(negedge clk) begin
        if (tick_c >= tick_k - 1) begin
            tick_c   = 0;
            tick_int = 1'b1;
        end else begin
            tick_c   = tick_c + 1;
            tick_int = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic load_latch(input int t, input int v);
        bus_write(4'(4 * t + 1), 8'(v >> 8));
        bus_write(4'(4 * t + 3), 8'(v));
    endtask

    task automatic read_count(input int t, output int v);
        int hi, lo;
        bus_read(4'(4 * t + 1), hi);
        bus_read(4'(4 * t + 3), lo);
        v = (hi << 8) | lo;
    endtask

    task automatic pulse_ext3();
        @(negedge clk); ext_tick3 = 1'b1;
        @(negedge clk); ext_tick3 = 1'b0;
    endtask

    task automatic measure(input int idx, output int cyc);
        logic p;
        int n;
        p = tmr_out[idx];
        n = 0;
        while (tmr_out[idx] == p && n < 40000) begin @(negedge clk); n++; end
        p = tmr_out[idx];
        cyc = 0;
        while (tmr_out[idx] == p && cyc < 40000) begin @(negedge clk); cyc++; end
    endtask

    function automatic int exp_period(input bit m8, input int lv);
        int lo, hi;
        if (!m8) return (lv <= 1) ? 1 : lv;
        lo = lv & 8'hFF;
        hi = (lv >> 8) & 8'hFF;
        return ((lo <= 1) ? 1 : lo) * (hi + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, x, st, cyc, seed_use;
        seed_use = int'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk("R2", "irq after reset", int'(irq), 0);
        chk("R2", "outputs after reset", int'(tmr_out), 0);
        bus_read(4'h3, st);
        chk("R2", "status after reset", st, 0);
        read_count(1, v);
        chk("R2", "counter1 after reset", v, 16'hFFFF);

        // R1 select CR3 while chip hold stays on; R3 hold
        bus_write(4'h3, 8'h00);
        bus_write(4'h1, 8'h82);
        load_latch(3, 3);
        repeat (40) @(negedge clk);
        chk("R3", "timer3 pin under hold", int'(tmr_out[2]), 0);
        bus_read(4'h3, st);
        chk("R3", "status under hold", st, 0);
        read_count(3, v);
        chk("R3", "counter3 held at latch", v, 3);
        bus_read(4'h1, v);
        chk("R1", "read of offset 0x1", v, 0);
        bus_write(4'h3, 8'h01);
        bus_write(4'h1, 8'h00);
        measure(2, cyc);
        chk("R1", "timer3 period via CR3 write", cyc, 3);

        // R8 cascade of timer 3 into timer 2
        bus_write(4'h3, 8'h81);
        load_latch(2, 4);
        measure(1, cyc);
        chk("R8", "cascaded timer2 period", cyc, 12);

        // R6 long periods
        bus_write(4'h1, 8'h82);
        load_latch(1, 2500);
        measure(0, cyc);
        chk("R6", "2500 preload period", cyc, 2500);
        load_latch(1, 5000);
        measure(0, cyc);
        chk("R6", "5000 preload period", cyc, 5000);

        // R7 directed dual 8-bit
        bus_write(4'h1, 8'h86);
        load_latch(1, 16'h0203);
        measure(0, cyc);
        chk("R7", "8-bit H=2 L=3 period", cyc, 9);

        // R6/R7/R8 random configurations on timer 1
        for (int i = 0; i < 8; i++) begin
            bit m8;
            int lv, k;
            m8 = 1'($urandom % 2);
            k  = 1 + int'($urandom % 3);
            if (m8) lv = (int'($urandom % 4) << 8) | (1 + int'($urandom % 9));
            else    lv = 2 + int'($urandom % 59);
            tick_k = k;
            bus_write(4'h1, m8 ? 8'h86 : 8'h82);
            load_latch(1, lv);
            measure(0, cyc);
            if (m8) chk("R7", "random 8-bit period", cyc, exp_period(m8, lv) * k);
            else    chk("R6", "random 16-bit period", cyc, exp_period(m8, lv) * k);
        end
        tick_k = 1;

        // R12 output enable off
        bus_write(4'h1, 8'h02);
        load_latch(1, 4);
        repeat (30) @(negedge clk);
        chk("R12", "pin held low when disabled", int'(tmr_out[0]), 0);
        bus_read(4'h3, st);
        chk("R9", "status bit0 after expiries", st & 1, 1);

        // R11 clear sequence, R10 composite
        bus_write(4'h1, 8'h40);
        bus_read(4'h3, st);
        read_count(1, v);
        chk("R11", "irq after status then counter read", int'(irq), 0);
        bus_write(4'h1, 8'h42);
        repeat (20) @(negedge clk);
        bus_write(4'h1, 8'h40);
        chk("R10", "irq with flag and enable", int'(irq), 1);
        read_count(1, v);
        chk("R11", "counter read alone keeps flag", int'(irq), 1);
        bus_read(4'h3, st);
        chk("R10", "status bit7 composite", (st >> 7) & 1, 1);
        chk("R9", "status bit0 flag", st & 1, 1);
        read_count(1, v);
        chk("R11", "irq after armed counter read", int'(irq), 0);
        bus_read(4'h3, st);
        chk("R11", "status bit0 cleared", st & 1, 0);
        bus_write(4'h1, 8'h02);
        repeat (20) @(negedge clk);
        bus_write(4'h1, 8'h00);
        chk("R10", "irq with interrupt disabled", int'(irq), 0);
        bus_read(4'h3, st);
        chk("R10", "status bit7 with interrupt disabled", (st >> 7) & 1, 0);

        // R4 no-reload latch write, R5 read capture, R8 external tick
        bus_write(4'h3, 8'h00);
        bus_write(4'h1, 8'h10);
        read_count(3, x);
        load_latch(3, 16'h1234);
        read_count(3, v);
        chk("R4", "no reload when bit4 set", v, x);
        bus_write(4'h1, 8'h00);
        load_latch(3, 16'h0777);
        read_count(3, v);
        chk("R4", "reload when bit4 clear", v, 16'h0777);
        bus_read(4'hD, v);
        chk("R5", "high byte read", v, 8'h07);
        pulse_ext3(); pulse_ext3(); pulse_ext3();
        bus_read(4'hF, v);
        chk("R5", "captured low byte", v, 8'h77);
        read_count(3, v);
        chk("R8", "external tick count", v, 16'h0774);

        finish_run();
    end
endmodule